// File: doc/BRIEF.md
# Conditional Trap Comparison Unit

This unit decides whether a conditional-trap operation raises a program trap. Each request brings two operands, a five-bit condition mask and a width select. The unit evaluates five relations between the operands at once: signed less-than, signed greater-than, equality, unsigned less-than and unsigned greater-than. It gates each relation with its mask bit. If any gated relation holds, the unit emits a trap pulse one clock later, together with a class code and a subtype code.

Width select low means word mode. In word mode only the low 32 bits of each operand are compared, and bit 31 is the sign bit. Width select high means doubleword mode, which compares all 64 bits. A request is presented by raising the strobe for one cycle. There is no handshake, and a new request may arrive on every cycle.

The output sequencer has two states. `IDLE` means no trap is being reported. `FIRE` means a trap pulse is on the outputs. The transitions are:
- `IDLE -> FIRE`, named `take`: a strobed request hits.
- `FIRE -> FIRE`, named `retake`: another hitting request is strobed while the pulse is shown.
- `FIRE -> IDLE`, named `drop`: no hitting request arrives.
- `IDLE -> IDLE`, named `hold`: nothing hits.

Top module: `cond_trap_unit`

## Requirements
- R1: After reset `trap_pulse` is 0, and `trap_class` and `trap_subtype` are both 0.
- R2: Mask bit 4 traps when A is less than B as signed numbers.
- R3: Mask bit 3 traps when A is greater than B as signed numbers.
- R4: Mask bit 2 traps when A equals B.
- R5: Mask bit 1 traps when A is less than B as unsigned numbers.
- R6: Mask bit 0 traps when A is greater than B as unsigned numbers.
- R7: A trap is the OR of the five gated relations. A mask of zero never traps, whatever the operands.
- R8: With `op_dword`=0, operand bits 63:32 have no effect, and bit 31 is the sign bit for the signed relations.
- R9: With `op_dword`=1, all 64 bits are compared, and bit 63 is the sign bit.
- R10: A request strobed at clock edge k shows its result on `trap_pulse` from edge k+1 until edge k+2. With no strobe, there is no pulse.
- R11: While `trap_pulse` is 1, `trap_class` is 4'h6 (program class) and `trap_subtype` is 4'h1 (trap). Otherwise both are 0.
- R12: With equal operands, a mask of 5'b11111 traps, and this is through the equality term only. A mask of 5'b11011 with equal operands does not trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request strobe, one cycle per request |
| op_dword | input | 1 | 1 selects a 64-bit compare, 0 selects a 32-bit compare |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| cond_mask | input | 5 | Condition enables. Bit 4 = signed <, bit 3 = signed >, bit 2 = equal, bit 1 = unsigned <, bit 0 = unsigned > |
| trap_pulse | output | 1 | One-cycle trap indication |
| trap_class | output | 4 | Exception class code (6 when a trap is shown) |
| trap_subtype | output | 4 | Exception subtype code (1 when a trap is shown) |

## Verification
Each condition bit is first tried alone against operand pairs where its relation holds and where it fails. This separates a swapped or missing term from a correct one.

Operand pairs are also chosen so that the signed and unsigned orderings disagree, for example a negative A against a small positive B. These pairs show whether a term uses the wrong signedness.

The same operand pairs are repeated in both widths, with junk placed in the upper halves, so that a compare which uses the wrong width or the wrong sign bit gives a different answer.

Zero and all-ones masks on equal operands check the OR of the terms. Back-to-back strobes followed by a miss check the pulse timing and the return to `IDLE`.

// File: rtl/cond_trap_pkg.sv
package cond_trap_pkg;

    localparam int unsigned NUM_COND = 5;
    localparam int unsigned CODE_W   = 4;

    localparam logic [CODE_W-1:0] CLASS_PROGRAM = 4'h6;
    localparam logic [CODE_W-1:0] SUBTYPE_TRAP  = 4'h1;
    localparam logic [CODE_W-1:0] CODE_NONE     = '0;

    // Field order matches the mask bit positions (slt is bit 4).
    typedef struct packed {
        logic slt;
        logic sgt;
        logic eq;
        logic ult;
        logic ugt;
    } rel_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FIRE = 1'b1
    } trap_state_e;

endpackage

// File: rtl/cond_trap_relate.sv
module cond_trap_relate
    import cond_trap_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter int unsigned WLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dword,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output rel_t            rel
);
    localparam int unsigned EXT = XLEN - WLEN;

    logic [XLEN-1:0] a_sx, b_sx, a_zx, b_zx;

    // Word mode: sign-extend for the signed relations, zero-extend for the
    // unsigned ones. Both keep only the low WLEN bits.
    always_comb begin
        if (dword) begin
            a_sx = a;
            b_sx = b;
            a_zx = a;
            b_zx = b;
        end else begin
            a_sx = {{EXT{a[WLEN-1]}}, a[WLEN-1:0]};
            b_sx = {{EXT{b[WLEN-1]}}, b[WLEN-1:0]};
            a_zx = {{EXT{1'b0}}, a[WLEN-1:0]};
            b_zx = {{EXT{1'b0}}, b[WLEN-1:0]};
        end
    end

    always_comb begin
        rel.slt = $signed(a_sx) < $signed(b_sx);
        rel.sgt = $signed(a_sx) > $signed(b_sx);
        rel.eq  = a_zx == b_zx;
        rel.ult = a_zx < b_zx;
        rel.ugt = a_zx > b_zx;
    end

    // R2 R3 R4: exactly one signed ordering holds
    signed_trichotomy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rel.slt, rel.eq, rel.sgt}) == 1);

    // R5 R6: exactly one unsigned ordering holds
    unsigned_trichotomy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rel.ult, rel.eq, rel.ugt}) == 1);

    // R8: in word mode, equal low halves give equality whatever the upper halves hold
    word_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dword && a[WLEN-1:0] == b[WLEN-1:0]) |-> rel.eq);

endmodule

// File: rtl/cond_trap_select.sv
module cond_trap_select
    import cond_trap_pkg::*;
(
    input  rel_t                mask,
    input  rel_t                rel,
    output logic [NUM_COND-1:0] hits,
    output logic                any_hit
);
    logic [NUM_COND-1:0] mask_v, rel_v;

    assign mask_v = mask;
    assign rel_v  = rel;

    for (genvar g = 0; g < NUM_COND; g++) begin : g_gate
        assign hits[g] = mask_v[g] & rel_v[g];
    end

    assign any_hit = |hits;

endmodule

// File: rtl/cond_trap_seq.sv
module cond_trap_seq
    import cond_trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              hit,
    output logic              pulse,
    output logic [CODE_W-1:0] cls,
    output logic [CODE_W-1:0] sub
);
    trap_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = (strobe && hit) ? ST_FIRE : ST_IDLE; // take / hold
            ST_FIRE: state_d = (strobe && hit) ? ST_FIRE : ST_IDLE; // retake / drop
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_FIRE: begin
                pulse = 1'b1;
                cls   = CLASS_PROGRAM;
                sub   = SUBTYPE_TRAP;
            end
            default: begin
                pulse = 1'b0;
                cls   = CODE_NONE;
                sub   = CODE_NONE;
            end
        endcase
    end

    // R10: a pulse only follows a strobe in the previous cycle
    pulse_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(strobe));

    // R10: without a strobe, a shown pulse drops after one cycle
    pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !strobe) |=> !pulse);

    // R11: codes are present exactly while the pulse is shown
    code_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse ? (cls == CLASS_PROGRAM && sub == SUBTYPE_TRAP)
              : (cls == CODE_NONE && sub == CODE_NONE));

endmodule

// File: rtl/cond_trap_unit.sv
module cond_trap_unit
    import cond_trap_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter int unsigned WLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_dword,
    input  logic [XLEN-1:0]   op_a,
    input  logic [XLEN-1:0]   op_b,
    input  logic [NUM_COND-1:0] cond_mask,
    output logic              trap_pulse,
    output logic [CODE_W-1:0] trap_class,
    output logic [CODE_W-1:0] trap_subtype
);
    rel_t                rel;
    rel_t                mask_s;
    logic [NUM_COND-1:0] hits;
    logic                any_hit;

    assign mask_s = cond_mask;

    cond_trap_relate #(.XLEN(XLEN), .WLEN(WLEN)) u_relate (
        .clk   (clk),
        .rst_n (rst_n),
        .dword (op_dword),
        .a     (op_a),
        .b     (op_b),
        .rel   (rel)
    );

    cond_trap_select u_select (
        .mask    (mask_s),
        .rel     (rel),
        .hits    (hits),
        .any_hit (any_hit)
    );

    cond_trap_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (op_valid),
        .hit    (any_hit),
        .pulse  (trap_pulse),
        .cls    (trap_class),
        .sub    (trap_subtype)
    );

    // R7: a strobe with an empty mask never produces a pulse
    zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && cond_mask == '0) |=> !trap_pulse);

    // R12: equal operands hit through the equality term alone
    eq_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_a == op_b) |-> (hits == (cond_mask & 5'b00100)));

    // R7: a strobe with any gated hit produces a pulse on the next cycle
    hit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && hits != '0) |=> trap_pulse);

endmodule

// File: tb/cond_trap_unit_bench.sv
module cond_trap_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_dword = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [4:0]  cond_mask = '0;
    logic        trap_pulse;
    logic [3:0]  trap_class;
    logic [3:0]  trap_subtype;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    cond_trap_unit u_cond_trap_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_dword(op_dword),
        .op_a(op_a), .op_b(op_b), .cond_mask(cond_mask),
        .trap_pulse(trap_pulse), .trap_class(trap_class), .trap_subtype(trap_subtype)
    );

    function automatic bit model(input logic [63:0] a, input logic [63:0] b,
                                 input logic [4:0] m, input bit dw);
        longint sa, sb;
        longint unsigned ua, ub;
        if (dw) begin
            sa = a; sb = b; ua = a; ub = b;
        end else begin
            sa = longint'($signed(a[31:0])); sb = longint'($signed(b[31:0]));
            ua = {32'd0, a[31:0]}; ub = {32'd0, b[31:0]};
        end
        return (m[4] && sa < sb) || (m[3] && sa > sb) || (m[2] && ua == ub) ||
               (m[1] && ua < ub) || (m[0] && ua > ub);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One request; result checked at the following negedge, then the drop.
    task automatic apply(input string req, input logic [63:0] a, input logic [63:0] b,
                         input logic [4:0] m, input bit dw, input bit exp_override,
                         input bit use_override);
        bit exp;
        exp = use_override ? exp_override : model(a, b, m, dw);
        @(negedge clk);
        op_a = a; op_b = b; cond_mask = m; op_dword = dw; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        check(req, "pulse", {63'd0, trap_pulse}, {63'd0, exp});
        check("R11", "class", {60'd0, trap_class}, exp ? 64'h6 : 64'h0);
        check("R11", "subtype", {60'd0, trap_subtype}, exp ? 64'h1 : 64'h0);
        @(negedge clk);
        check("R10", "pulse after one cycle", {63'd0, trap_pulse}, 64'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "reset pulse", {63'd0, trap_pulse}, 64'd0);
        check("R1", "reset codes", {56'd0, trap_class, trap_subtype}, 64'd0);
    endtask

    task automatic t_signed_lt();
        apply("R2", 64'hFFFF_FFFF_FFFF_FFFE, 64'd3, 5'b10000, 1, 1, 1);
        apply("R2", 64'd3, 64'hFFFF_FFFF_FFFF_FFFE, 5'b10000, 1, 0, 1);
    endtask

    task automatic t_signed_gt();
        apply("R3", 64'd3, 64'hFFFF_FFFF_FFFF_FFFE, 5'b01000, 1, 1, 1);
        apply("R3", 64'd3, 64'd3, 5'b01000, 1, 0, 1);
    endtask

    task automatic t_equal();
        apply("R4", 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 5'b00100, 1, 1, 1);
        apply("R4", 64'd7, 64'd8, 5'b00100, 1, 0, 1);
    endtask

    task automatic t_unsigned_lt();
        apply("R5", 64'd3, 64'hFFFF_FFFF_FFFF_FFFE, 5'b00010, 1, 1, 1);
        apply("R5", 64'hFFFF_FFFF_FFFF_FFFE, 64'd3, 5'b00010, 1, 0, 1);
    endtask

    task automatic t_unsigned_gt();
        apply("R6", 64'hFFFF_FFFF_FFFF_FFFE, 64'd3, 5'b00001, 1, 1, 1);
        apply("R6", 64'd2, 64'd3, 5'b00001, 1, 0, 1);
    endtask

    task automatic t_zero_mask();
        apply("R7", 64'd1, 64'd9, 5'b00000, 1, 0, 1);
        apply("R7", 64'd5, 64'd5, 5'b00000, 0, 0, 1);
        apply("R7", 64'd1, 64'd9, 5'b01011, 1, 1, 1); // only unsigned < holds
    endtask

    task automatic t_word_mode();
        apply("R8", 64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_0005, 5'b00100, 0, 1, 1);
        apply("R8", 64'h0000_0000_8000_0000, 64'd1, 5'b10000, 0, 1, 1);
        apply("R8", 64'hAAAA_0000_0000_0001, 64'h5555_0000_0000_0002, 5'b00001, 0, 0, 1);
    endtask

    task automatic t_dword_mode();
        apply("R9", 64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_0005, 5'b00100, 1, 0, 1);
        apply("R9", 64'h0000_0000_8000_0000, 64'd1, 5'b10000, 1, 0, 1);
        apply("R9", 64'h0000_0000_8000_0000, 64'd1, 5'b00001, 1, 1, 1);
        apply("R9", 64'h8000_0000_0000_0000, 64'd0, 5'b10000, 1, 1, 1);
    endtask

    task automatic t_pulse_timing();
        @(negedge clk);
        op_a = 64'd1; op_b = 64'd2; cond_mask = 5'b00010; op_dword = 1; op_valid = 1;
        @(negedge clk);
        check("R10", "first of back-to-back", {63'd0, trap_pulse}, 64'd1);
        op_a = 64'd4; op_b = 64'd4; cond_mask = 5'b00100;
        @(negedge clk);
        check("R10", "second of back-to-back", {63'd0, trap_pulse}, 64'd1);
        op_a = 64'd4; op_b = 64'd9; cond_mask = 5'b00001;
        @(negedge clk);
        op_valid = 0;
        check("R10", "miss after pulses", {63'd0, trap_pulse}, 64'd0);
        op_a = 64'd1; op_b = 64'd2; cond_mask = 5'b00010;
        @(negedge clk);
        @(negedge clk);
        check("R10", "no strobe no pulse", {63'd0, trap_pulse}, 64'd0);
    endtask

    task automatic t_all_ones_equal();
        apply("R12", 64'hDEAD_BEEF_0000_0042, 64'hDEAD_BEEF_0000_0042, 5'b11111, 1, 1, 1);
        apply("R12", 64'hDEAD_BEEF_0000_0042, 64'hDEAD_BEEF_0000_0042, 5'b11011, 1, 0, 1);
        apply("R12", 64'h0000_0000_0000_0042, 64'hFFFF_FFFF_0000_0042, 5'b11011, 0, 0, 1);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_signed_lt();
        t_signed_gt();
        t_equal();
        t_unsigned_lt();
        t_unsigned_gt();
        t_zero_mask();
        t_word_mode();
        t_dword_mode();
        t_pulse_timing();
        t_all_ones_equal();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule